// File: doc/BRIEF.md
# Edge-Selectable Event Counter Control

This block keeps three free-standing channel counters. Each one runs in one of two modes. In timer mode it steps once on every clock. In counter mode it steps only when one of the input edges chosen for it is seen on three shared capture inputs. Each of the three inputs has a rising edge and a falling edge, so there are six edges to choose from. A counter can be set to follow any subset of those six.

Software reaches the mode and edge choices through one control word. Software never writes that word directly. A write-one-to-set port turns bits on, and a write-one-to-clear port turns bits off. The current value is presented on a read-only output. The capture inputs are asynchronous, so each one is synchronised on entry. Its edges are then turned into single-clock pulses before they reach the channels.

Top module: `evc_ctrl`

## Requirements
- R1: While reset is held, the control word reads 0 and all three counts read 0.
- R2: A set write ORs its one bits into the control word. Bits that are zero in the written data keep their value.
- R3: A clear write forces its one bits of the control word to 0. Bits that are zero in the written data keep their value.
- R4: If a set write and a clear write land in the same cycle, the clear wins for every bit named in both. Other bits named by the set are still set.
- R5: Only bits 0 to 17 (edge enables) and bits 29 to 31 (modes) are implemented. Bits 18 to 28 always read 0.
- R6: When the mode bit of channel c (bit 29+c) is 0, that channel's count rises by exactly 1 on every clock and wraps modulo 2^32.
- R7: Channel c uses enable bits 6c to 6c+5. Bit 6c+2i enables the rising edge of input i, and bit 6c+2i+1 enables its falling edge. When the channel's mode bit is 1, each enabled edge advances its count by one.
- R8: In counter mode, an edge whose enable bit is 0 leaves that channel's count unchanged.
- R9: In timer mode, the edge enables and the input activity have no effect. The count still rises by exactly one per clock.
- R10: If several enabled edges of one channel occur in the same cycle, the count advances by one only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cap_in | input | 3 | Asynchronous capture inputs 0..2 |
| set_we | input | 1 | Set-address write strobe |
| set_data | input | 32 | Bits to set |
| clr_we | input | 1 | Clear-address write strobe |
| clr_data | input | 32 | Bits to clear |
| ctrl_q | output | 32 | Control word read value |
| cnt_all | output | 96 | Channel counts, channel c at bits 32c+31..32c |

## Verification
The assertions assume that each capture input holds every level for at least two clocks. Without that, the synchroniser could swallow a pulse and the edge pulses would not match input transitions one for one. The assertions also assume that the capture inputs are low while reset is released, so that no spurious edge appears right after reset.

The stimulus changes capture inputs only on falling clock edges and then holds them for four cycles. It keeps them low across every reset. It drives set and clear writes as one-cycle strobes, with data that may include reserved bits.

// File: rtl/evc_pkg.sv
package evc_pkg;
  localparam int NUM_CH      = 3;
  localparam int NUM_IN      = 3;
  localparam int EDGE_PER_CH = 2 * NUM_IN;
  localparam int CTRL_W      = 32;
  localparam int MODE_LSB    = 29;

  // implemented bits: all edge enables plus one mode bit per channel
  function automatic logic [CTRL_W-1:0] ctrl_mask();
    logic [CTRL_W-1:0] m;
    m = '0;
    for (int b = 0; b < NUM_CH * EDGE_PER_CH; b++) m[b] = 1'b1;
    for (int c = 0; c < NUM_CH; c++) m[MODE_LSB + c] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/evc_rst_sync.sv
module evc_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_ns
);
  logic stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= 1'b0;
      rst_ns  <= 1'b0;
    end else begin
      stage_q <= 1'b1;
      rst_ns  <= stage_q;
    end
  end
endmodule

// File: rtl/evc_edge_det.sv
module evc_edge_det #(
  parameter int N = 3
) (
  input  logic           clk,
  input  logic           rst_ns,
  input  logic [N-1:0]   pin,
  output logic [2*N-1:0] edges
);
  logic [N-1:0] meta_q, sync_q, prev_q;
  logic [N-1:0] rise, fall;

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      meta_q <= '0;
      sync_q <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= pin;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  assign rise = sync_q & ~prev_q;
  assign fall = ~sync_q & prev_q;

  // interleave: even bit = rising, odd bit = falling, per input
  for (genvar i = 0; i < N; i++) begin : g_pair
    assign edges[2*i]   = rise[i];
    assign edges[2*i+1] = fall[i];
  end
endmodule

// File: rtl/evc_ctrl_reg.sv
module evc_ctrl_reg #(
  parameter int          W    = 32,
  parameter logic [W-1:0] MASK = '1
) (
  input  logic         clk,
  input  logic         rst_ns,
  input  logic         set_we,
  input  logic [W-1:0] set_data,
  input  logic         clr_we,
  input  logic [W-1:0] clr_data,
  output logic [W-1:0] q
);
  logic [W-1:0] nxt;
  logic         upd;

  assign upd = set_we | clr_we;

  always_comb begin
    nxt = q;
    if (set_we) nxt = nxt | set_data;
    if (clr_we) nxt = nxt & ~clr_data;  // clear applied last: wins
    nxt = nxt & MASK;
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns)  q <= '0;
    else if (upd) q <= nxt;
  end
endmodule

// File: rtl/evc_chan.sv
module evc_chan #(
  parameter int CW = 32,
  parameter int NE = 6
) (
  input  logic          clk,
  input  logic          rst_ns,
  input  logic          mode,
  input  logic [NE-1:0] en,
  input  logic [NE-1:0] edges,
  output logic [CW-1:0] cnt
);
  logic          step;
  logic [CW-1:0] cnt_d;

  always_comb begin
    step  = mode ? |(en & edges) : 1'b1;
    cnt_d = cnt + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns)   cnt <= '0;
    else if (step) cnt <= cnt_d;
  end
endmodule

// File: rtl/evc_ctrl.sv
module evc_ctrl #(
  parameter int CNT_W = 32
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [evc_pkg::NUM_IN-1:0]     cap_in,
  input  logic                           set_we,
  input  logic [evc_pkg::CTRL_W-1:0]     set_data,
  input  logic                           clr_we,
  input  logic [evc_pkg::CTRL_W-1:0]     clr_data,
  output logic [evc_pkg::CTRL_W-1:0]     ctrl_q,
  output logic [evc_pkg::NUM_CH*CNT_W-1:0] cnt_all
);
  import evc_pkg::*;

  localparam logic [CTRL_W-1:0] CTRL_MASK = ctrl_mask();
  localparam int NE = EDGE_PER_CH;

  logic          rst_ns;
  logic [NE-1:0] edge_vec;

  evc_rst_sync u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_ns (rst_ns)
  );

  evc_edge_det #(.N(NUM_IN)) u_edge (
    .clk    (clk),
    .rst_ns (rst_ns),
    .pin    (cap_in),
    .edges  (edge_vec)
  );

  evc_ctrl_reg #(.W(CTRL_W), .MASK(CTRL_MASK)) u_reg (
    .clk      (clk),
    .rst_ns   (rst_ns),
    .set_we   (set_we),
    .set_data (set_data),
    .clr_we   (clr_we),
    .clr_data (clr_data),
    .q        (ctrl_q)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    evc_chan #(.CW(CNT_W), .NE(NE)) u_chan (
      .clk    (clk),
      .rst_ns (rst_ns),
      .mode   (ctrl_q[MODE_LSB + c]),
      .en     (ctrl_q[c*NE +: NE]),
      .edges  (edge_vec),
      .cnt    (cnt_all[c*CNT_W +: CNT_W])
    );
  end
endmodule

// File: rtl/evc_ctrl_chk.sv
module evc_ctrl_chk #(
  parameter int                         CNT_W = 32,
  parameter logic [evc_pkg::CTRL_W-1:0] MASK  = '1
) (
  input logic                             clk,
  input logic                             rst_ns,
  input logic                             set_we,
  input logic [evc_pkg::CTRL_W-1:0]       set_data,
  input logic                             clr_we,
  input logic [evc_pkg::CTRL_W-1:0]       clr_data,
  input logic [evc_pkg::CTRL_W-1:0]       ctrl_q,
  input logic [evc_pkg::NUM_CH*CNT_W-1:0] cnt_all,
  input logic [evc_pkg::EDGE_PER_CH-1:0]  edge_vec
);
  import evc_pkg::*;
  localparam int NE = EDGE_PER_CH;

  AST_SET_TAKES: assert property (@(posedge clk) disable iff (!rst_ns)
    (set_we && !clr_we) |=> ((ctrl_q & $past(set_data & MASK)) == $past(set_data & MASK))); // R2
  AST_CLR_TAKES: assert property (@(posedge clk) disable iff (!rst_ns)
    clr_we |=> ((ctrl_q & $past(clr_data)) == '0)); // R3
  AST_CLR_WINS: assert property (@(posedge clk) disable iff (!rst_ns)
    (set_we && clr_we) |=> ((ctrl_q & $past(set_data & clr_data)) == '0)); // R4
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_ns)
    (!set_we && !clr_we) |=> $stable(ctrl_q)); // R2
  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_ns)
    ((ctrl_q & ~MASK) == '0)); // R5

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
    AST_TIMER_STEP: assert property (@(posedge clk) disable iff (!rst_ns)
      !ctrl_q[MODE_LSB + c] |=>
        ((cnt_all[c*CNT_W +: CNT_W] - $past(cnt_all[c*CNT_W +: CNT_W])) == CNT_W'(1))); // R6
    AST_NO_EDGE_HOLD: assert property (@(posedge clk) disable iff (!rst_ns)
      (ctrl_q[MODE_LSB + c] && ((ctrl_q[c*NE +: NE] & edge_vec) == '0)) |=>
        $stable(cnt_all[c*CNT_W +: CNT_W])); // R8
    AST_SINGLE_STEP: assert property (@(posedge clk) disable iff (!rst_ns)
      (ctrl_q[MODE_LSB + c] && ((ctrl_q[c*NE +: NE] & edge_vec) != '0)) |=>
        ((cnt_all[c*CNT_W +: CNT_W] - $past(cnt_all[c*CNT_W +: CNT_W])) == CNT_W'(1))); // R10
  end
endmodule

bind evc_ctrl evc_ctrl_chk #(.CNT_W(CNT_W), .MASK(CTRL_MASK)) u_chk (
  .clk      (clk),
  .rst_ns   (rst_ns),
  .set_we   (set_we),
  .set_data (set_data),
  .clr_we   (clr_we),
  .clr_data (clr_data),
  .ctrl_q   (ctrl_q),
  .cnt_all  (cnt_all),
  .edge_vec (edge_vec)
);

// File: tb/evc_ctrl_bench.sv
module evc_ctrl_bench;
  logic        clk;
  logic        rst_n;
  logic [2:0]  cap_in;
  logic        set_we, clr_we;
  logic [31:0] set_data, clr_data;
  logic [31:0] ctrl_q;
  logic [95:0] cnt_all;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  localparam logic [31:0] MASK_EXP = 32'hE003_FFFF;

  evc_ctrl u_evc_ctrl (
    .clk(clk), .rst_n(rst_n), .cap_in(cap_in),
    .set_we(set_we), .set_data(set_data),
    .clr_we(clr_we), .clr_data(clr_data),
    .ctrl_q(ctrl_q), .cnt_all(cnt_all)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [31:0] cnt(input int c);
    return cnt_all[c*32 +: 32];
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic s, input logic [31:0] sd, input logic c, input logic [31:0] cd);
    @(negedge clk);
    set_we = s; set_data = sd; clr_we = c; clr_data = cd;
    @(negedge clk);
    set_we = 0; clr_we = 0; set_data = '0; clr_data = '0;
  endtask

  task automatic toggle(input logic [2:0] which);
    @(negedge clk);
    cap_in = cap_in ^ which;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset;
    rst_n = 0; cap_in = '0; set_we = 0; clr_we = 0; set_data = '0; clr_data = '0;
    repeat (3) @(negedge clk);
    check("R1 ctrl", ctrl_q, 32'h0);
    for (int c = 0; c < 3; c++) check("R1 count", cnt(c), 32'h0);
    rst_n = 1;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_set_clear;
    wr(1, 32'h0000_0005, 0, '0);
    wr(1, 32'h0000_0030, 0, '0);
    check("R2 set or", ctrl_q, 32'h0000_0035);
    wr(0, '0, 1, 32'h0000_0011);
    check("R3 clear", ctrl_q, 32'h0000_0024);
    wr(1, 32'h0000_0003, 1, 32'h0000_0006);
    check("R4 clear wins", ctrl_q, 32'h0000_0021);
    wr(0, '0, 1, 32'hFFFF_FFFF);
    check("R3 clear all", ctrl_q, 32'h0);
  endtask

  task automatic t_reserved;
    wr(1, 32'hFFFF_FFFF, 0, '0);
    check("R5 reserved", ctrl_q, MASK_EXP);
    wr(0, '0, 1, 32'hFFFF_FFFF);
  endtask

  task automatic t_timer;
    logic [31:0] b0, b1, b2;
    @(negedge clk);
    b0 = cnt(0); b1 = cnt(1); b2 = cnt(2);
    repeat (20) @(negedge clk);
    check("R6 timer ch0", cnt(0) - b0, 32'd20);
    check("R6 timer ch1", cnt(1) - b1, 32'd20);
    check("R6 timer ch2", cnt(2) - b2, 32'd20);
  endtask

  task automatic t_timer_ignores;
    logic [31:0] b;
    wr(1, 32'h0000_003F, 0, '0);
    @(negedge clk);
    b = cnt(0);
    cap_in = 3'b111;
    repeat (6) @(negedge clk);
    cap_in = 3'b000;
    repeat (6) @(negedge clk);
    check("R9 timer ignores edges", cnt(0) - b, 32'd12);
    wr(0, '0, 1, 32'hFFFF_FFFF);
  endtask

  task automatic t_counter_map;
    logic [31:0] b [3];
    wr(1, 32'hE000_0000, 0, '0);
    for (int c = 0; c < 3; c++) begin
      for (int e = 0; e < 6; e++) begin
        wr(0, '0, 1, 32'h0003_FFFF);
        wr(1, 32'h1 << (c*6 + e), 0, '0);
        for (int k = 0; k < 3; k++) b[k] = cnt(k);
        toggle(3'b001 << (e/2));
        toggle(3'b001 << (e/2));
        check("R7 edge map", cnt(c) - b[c], 32'd1);
        check("R8 disabled", cnt((c+1)%3) - b[(c+1)%3], 32'd0);
      end
    end
  endtask

  task automatic t_coincident;
    logic [31:0] b;
    wr(0, '0, 1, 32'h0003_FFFF);
    wr(1, 32'h0000_0005, 0, '0);
    b = cnt(0);
    toggle(3'b011);
    check("R10 coincident", cnt(0) - b, 32'd1);
    toggle(3'b011);
    check("R8 falls disabled", cnt(0) - b, 32'd1);
    wr(0, '0, 1, 32'hFFFF_FFFF);
  endtask

  initial begin
    t_reset();
    t_timer();
    t_set_clear();
    t_reserved();
    t_timer_ignores();
    t_counter_map();
    t_coincident();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule